// File: doc/BRIEF.md
# Segmented Current-Steering DAC Control Decoder

This block sits between the digital sample stream and the switch array of a segmented current-steering converter. Each input word is cut into an upper field and a lower field. The upper field is expanded into a thermometer code that drives a bank of equal-weight unit cells. The lower field drives the binary-weighted cells directly, with no decoding.

The unit cells are not switched left to right. The first cell to turn on is the one at the centre of the physical row. Each further code step then adds the nearest unused cell, taking one below the centre and then one above, and so on outward. This keeps the linear error caused by gradients in the supply and ground rails small.

All enables leave the block through one register bank, so every cell control changes on the same clock edge. The upper and lower segments therefore stay aligned, and a major-carry step such as 011 to 100 shows no skew between lines.

Top module: `segdac_front`

## Requirements
- R1: The input word `data_in` is MSB_W+LSB_W bits wide. Bits [MSB_W+LSB_W-1:LSB_W] form the unit field U. Bits [LSB_W-1:0] form the binary field.
- R2: After one clock edge, the number of set bits in `unit_en` equals U. The bank has 2^MSB_W-1 unit enables.
- R3: The unit enables are monotonic in U. An element that is on for a value U stays on for every larger U.
- R4: Bit e-1 of `unit_en` controls physical element e. Elements turn on centre-outward from c = 2^(MSB_W-1): first c, then c-1, c+1, c-2, c+2, and so on. For MSB_W=3 the order is 4,3,5,2,6,1,7. A value U enables the first U elements of this order.
- R5: `bin_en[i]` equals bit i of the binary field of the word sampled at the previous edge. The binary field is not decoded.
- R6: Both segments have exactly one clock cycle of latency. A word applied before edge n appears on all enables just after edge n, and the enables hold their old value until that edge.
- R7: When `rst_n` goes low, all enables clear at once, without waiting for a clock edge. They stay zero while reset is held. Reset release is resynchronised over two clock edges.
- R8: U = 1 enables only the centre element c. U = 0 enables no unit element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all enables update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_in | input | MSB_W+LSB_W | Binary sample word |
| unit_en | output | 2^MSB_W-1 | Retimed enables of the unit cells, bit e-1 = element e |
| bin_en | output | max(LSB_W,1) | Retimed enables of the binary cells, bit i has weight 2^i |

## Verification
The bench builds the block with a three-bit unit field and a two-bit binary field. This gives seven unit cells, so the centre-outward order can be compared against the explicit sequence 4,3,5,2,6,1,7. The 32 possible words are few enough to sweep completely, both upward and downward, which exercises every major-carry step. A pseudo-random stream follows the sweeps to test back-to-back code jumps. A reset is also applied in the middle of the run to check the asynchronous clear.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // Centre element index (1-based) of a row of 2^msb_w-1 unit cells.
  function automatic int centre_of(input int msb_w);
    return 1 << (msb_w - 1);
  endfunction

  // Rank (0-based) at which physical element e (1-based) turns on.
  function automatic int rank_of(input int e, input int msb_w);
    int c;
    c = centre_of(msb_w);
    if (e == c) return 0;
    else if (e < c) return 2 * (c - e) - 1;
    else return 2 * (e - c);
  endfunction

endpackage

// File: rtl/segdac_rst_sync.sv
module segdac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;
  logic meta_d;
  logic out_d;

  always_comb begin
    meta_d = 1'b1;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= meta_d;
      rst_q_n <= out_d;
    end
  end
endmodule

// File: rtl/segdac_thermo.sv
module segdac_thermo #(
  parameter int MSB_W = 4
) (
  input  logic [MSB_W-1:0]        code,
  output logic [(1<<MSB_W)-2:0]   therm
);
  localparam int N_UNIT = (1 << MSB_W) - 1;

  // therm[k] is set when at least k+1 unit cells must be on.
  for (genvar k = 0; k < N_UNIT; k++) begin : g_rank
    localparam logic [MSB_W-1:0] LIMIT = MSB_W'(k);
    assign therm[k] = (code > LIMIT);
  end
endmodule

// File: rtl/segdac_perm.sv
module segdac_perm #(
  parameter int MSB_W = 4
) (
  input  logic [(1<<MSB_W)-2:0] rank_on,
  output logic [(1<<MSB_W)-2:0] phys_on
);
  import segdac_pkg::*;
  localparam int N_UNIT = (1 << MSB_W) - 1;

  // Physical element e+1 follows the thermometer rank assigned to it.
  for (genvar e = 0; e < N_UNIT; e++) begin : g_elem
    localparam int RANK = rank_of(e + 1, MSB_W);
    assign phys_on[e] = rank_on[RANK];
  end
endmodule

// File: rtl/segdac_retime.sv
module segdac_retime #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  // One flop per control line; all share one edge.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) q[i] <= 1'b0;
      else          q[i] <= q_nxt[i];
    end
  end
endmodule

// File: rtl/segdac_front.sv
module segdac_front #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 4,
  localparam int WORD_W = MSB_W + LSB_W,
  localparam int N_UNIT = (1 << MSB_W) - 1,
  localparam int BIN_W  = (LSB_W > 0) ? LSB_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] data_in,
  output logic [N_UNIT-1:0] unit_en,
  output logic [BIN_W-1:0]  bin_en
);
  localparam int CTRL_W = N_UNIT + BIN_W;

  logic              rst_q_n;
  logic [MSB_W-1:0]  unit_code;
  logic [N_UNIT-1:0] rank_on;
  logic [N_UNIT-1:0] phys_on;
  logic [BIN_W-1:0]  bin_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_q;

  segdac_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign unit_code = data_in[WORD_W-1 -: MSB_W];

  if (LSB_W > 0) begin : g_bin
    assign bin_d = data_in[BIN_W-1:0];
  end else begin : g_nobin
    assign bin_d = '0;
  end

  segdac_thermo #(.MSB_W(MSB_W)) u_thermo (
    .code  (unit_code),
    .therm (rank_on)
  );

  segdac_perm #(.MSB_W(MSB_W)) u_perm (
    .rank_on (rank_on),
    .phys_on (phys_on)
  );

  assign ctrl_d = {phys_on, bin_d};

  segdac_retime #(.W(CTRL_W)) u_retime (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .d       (ctrl_d),
    .q       (ctrl_q)
  );

  assign unit_en = ctrl_q[CTRL_W-1:BIN_W];
  assign bin_en  = ctrl_q[BIN_W-1:0];
endmodule

// File: rtl/segdac_front_chk.sv
module segdac_front_chk #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 4,
  localparam int WORD_W = MSB_W + LSB_W,
  localparam int N_UNIT = (1 << MSB_W) - 1,
  localparam int BIN_W  = (LSB_W > 0) ? LSB_W : 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [WORD_W-1:0] data_in,
  input logic [N_UNIT-1:0] unit_en,
  input logic [BIN_W-1:0]  bin_en
);
  localparam int CTR = 1 << (MSB_W - 1);

  logic [1:0]       up_cnt;
  logic [MSB_W-1:0] ufield;
  logic [BIN_W-1:0] bfield;

  assign ufield = data_in[WORD_W-1 -: MSB_W];
  if (LSB_W > 0) begin : g_b
    assign bfield = data_in[BIN_W-1:0];
  end else begin : g_nb
    assign bfield = '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)           up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  // R2
  a_r2_count: assert property (@(posedge clk) disable iff (!rst_q_n)
    (up_cnt >= 2'd1) |-> ($countones(unit_en) == int'($past(ufield))));

  // R5
  a_r5_binary: assert property (@(posedge clk) disable iff (!rst_q_n)
    (up_cnt >= 2'd1) |-> (bin_en == $past(bfield)));

  // R3
  a_r3_grow: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((up_cnt >= 2'd2) && ($past(ufield) >= $past(ufield, 2)))
      |-> ((unit_en & $past(unit_en)) == $past(unit_en)));

  // R8
  a_r8_centre: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((up_cnt >= 2'd1) && ($past(ufield) == MSB_W'(1)))
      |-> (unit_en == (N_UNIT'(1) << (CTR - 1))));

  // R7
  always @(negedge clk) begin
    if (rst_q_n === 1'b0) begin
      a_r7_clear: assert ((unit_en == '0) && (bin_en == '0));
    end
  end
endmodule

bind segdac_front segdac_front_chk #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .data_in (data_in),
  .unit_en (unit_en),
  .bin_en  (bin_en)
);

// File: tb/sim_segdac_front.sv
`timescale 1ns/1ps
module sim_segdac_front;
  localparam int MW = 3;
  localparam int LW = 2;
  localparam int NU = 7;

  logic          clk;
  logic          rst_n;
  logic [MW+LW-1:0] data_in;
  logic [NU-1:0] unit_en;
  logic [LW-1:0] bin_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int code; logic [NU-1:0] unit; logic [LW-1:0] bin; } item_t;
  item_t sbq[$];
  int    prev_code = -1;
  logic [NU-1:0] prev_unit;

  int ord[NU] = '{4, 3, 5, 2, 6, 1, 7};

  segdac_front #(.MSB_W(MW), .LSB_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .unit_en(unit_en), .bin_en(bin_en)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NU-1:0] exp_unit(input int u);
    logic [NU-1:0] v = '0;
    for (int j = 0; j < u; j++) v[ord[j]-1] = 1'b1;
    return v;
  endfunction

  // driver: applies one word and pushes its expected result
  task automatic drive(input int code);
    item_t it;
    @(negedge clk);
    data_in = (MW+LW)'(code);
    it.code = code;
    it.unit = exp_unit(code >> LW);
    it.bin  = LW'(code);
    sbq.push_back(it);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0 && rst_n) begin
      item_t it;
      it = sbq.pop_front();
      check(unit_en == it.unit, "R4 order", unit_en, it.unit);
      check($countones(unit_en) == (it.code >> LW), "R2 count", $countones(unit_en), it.code >> LW);
      check(bin_en == it.bin, "R5/R1 binary field", bin_en, it.bin);
      if (prev_code >= 0 && (it.code >> LW) >= (prev_code >> LW))
        check((unit_en & prev_unit) == prev_unit, "R3 monotonic", unit_en, prev_unit);
      if ((it.code >> LW) == 1)
        check(unit_en == 7'b0001000, "R8 centre first", unit_en, 7'b0001000);
      prev_code = it.code;
      prev_unit = unit_en;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 0;
    data_in = '1;
    repeat (3) @(negedge clk);
    check(unit_en == '0 && bin_en == '0, "R7 reset state", {unit_en, bin_en}, 0);
    rst_n = 1;
    data_in = '0;
    repeat (3) @(negedge clk);
    check(unit_en == '0, "R8 zero code", unit_en, 0);

    // R6: output holds until the edge after the word is applied
    drive(5'b10011);
    #1;
    check(unit_en == '0 && bin_en == '0, "R6 no early change", {unit_en, bin_en}, 0);
    @(negedge clk);
    for (int c = 0; c < 32; c++) drive(c);
    for (int c = 31; c >= 0; c--) drive(c);
    drive(5'b01111);
    drive(5'b10000);
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(int'(lfsr[4:0]));
    end
    @(negedge clk);
    @(negedge clk);

    // R7: asynchronous clear mid-run
    data_in = '1;
    @(negedge clk);
    @(negedge clk);
    check(unit_en == 7'h7f, "R2 full scale", unit_en, 7'h7f);
    #2;
    rst_n = 0;
    #1;
    check(unit_en == '0 && bin_en == '0, "R7 async clear", {unit_en, bin_en}, 0);
    @(negedge clk);
    check(unit_en == '0 && bin_en == '0, "R7 held in reset", {unit_en, bin_en}, 0);
    rst_n = 1;
    @(negedge clk);
    check(unit_en == '0, "R7 sync release", unit_en, 0);
    repeat (2) @(negedge clk);
    check(unit_en == 7'h7f && bin_en == 2'b11, "R6 after release", {unit_en, bin_en}, 9'h1ff);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule